// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a watchdog built from a free-running 32-bit up-counter and one equality comparator. Software reads the counter, adds its timeout margin (counter frequency times the timeout in seconds, kept below 2^32 - 1 so the target wraps at most once), and writes the sum into the target register. The same write both arms and refreshes the watchdog. There is no down-counter to reload.

The software sequence has three steps. It writes the target, clears any pending match flag, and then sets the arm bit. The arm bit is set-only: no write can clear it, and only the system reset does. When the counter reaches the target while the block is armed, the block emits a single-cycle reset request and sets a reset-cause flag. That flag has its own power-on reset, so it survives the system reset it caused and software can read it after reboot.

The interrupt enable only gates the interrupt output. It has no influence on the reset request. The bus port is a simple single-cycle register port: byte addresses, full 32-bit words, and combinational read data.

Top module: `mwd_top`

## Requirements
- R1: The counter (offset 0x00) advances by one every clock, modulo 2^32. A write loads the written value, and the count then advances from that value. A read returns the current count.
- R2: The target register (offset 0x04) is compared for exact equality with the counter every cycle, so a target that wrapped past 2^32 still matches. If a target write falls in the same cycle as an equality, the compare in that cycle uses the old target.
- R3: Status bit 0 (offset 0x08) is set the cycle after an equality, whether or not the block is armed. Writing 1 to bit 0 clears it and writing 0 leaves it unchanged. A new equality wins over a clear in the same cycle.
- R4: Arm bit 0 (offset 0x0C) is set by writing 1. Writing 0 has no effect, and only `rst_n` clears it.
- R5: `wdog_rst_req` is a one-cycle pulse in the cycle after an equality while armed. After one pulse, no further pulse occurs until `rst_n` is asserted.
- R6: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 (offset 0x10, read/write) are both 1. The interrupt enable does not affect R5.
- R7: Cause bit 0 (offset 0x14) is set together with the reset pulse and is not cleared by `rst_n`. It is cleared by `por_n` or by writing 1 to bit 0.
- R8: After reset the counter reads 0 (then counts), the target reads 0xFFFFFFFF, and status, arm, interrupt enable and cause read 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset, also clears the cause flag |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq | output | 1 | Match interrupt |
| wdog_rst_req | output | 1 | One-cycle reset request |

## Verification
The bench drives the block through several patterns, and each one separates a different fault:
- An unarmed equality shows that the status flag does not depend on the arm bit.
- A target write landing in the very cycle of equality shows whether the old or the new target was compared.
- A counter preset just below 2^32 with a small target checks that a wrapped target still matches.
- Repeated kicks followed by a lapse show that refreshing holds the request off and that the lapse produces exactly one pulse, even with the interrupt disabled.
- A second equality after firing shows that the pulse does not repeat.
- Separate system and power-on resets show which of the two clears the cause flag.

// File: rtl/mwd_pkg.sv
// Shared constants for the match-compare watchdog: register offsets and widths.
// Assumes byte addressing with word-aligned registers.
package mwd_pkg;
    parameter int unsigned DATA_W   = 32;
    parameter int unsigned ADDR_W   = 5;
    parameter int unsigned OFS_CNT  = 'h00;
    parameter int unsigned OFS_TGT  = 'h04;
    parameter int unsigned OFS_STS  = 'h08;
    parameter int unsigned OFS_ARM  = 'h0C;
    parameter int unsigned OFS_IEN  = 'h10;
    parameter int unsigned OFS_CAUSE = 'h14;
endpackage

// File: rtl/mwd_count.sv
// Free-running up-counter with a synchronous load.
// Assumes the load value is taken in the cycle the load strobe is high.
module mwd_count #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);
    // Count up by one each clock, or take the loaded value.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (ld) cnt <= ld_val;
        else         cnt <= cnt + W'(1);
    end

    // R1: without a load the count steps by exactly one
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld)) |-> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/mwd_match.sv
// Target register and equality comparator.
// Assumes the compare in any cycle sees the registered (old) target.
module mwd_match #(
    parameter int unsigned    W       = 32,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wval,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] tgt,
    output logic         hit
);
    // Hold the target; load it on a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)  tgt <= RST_VAL;
        else if (wr) tgt <= wval;
    end

    // Exact compare; wraparound needs no special handling.
    assign hit = rst_n && (cnt == tgt);

    // R2: the target only changes through a write
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr)) |-> $stable(tgt));
endmodule

// File: rtl/mwd_ctrl.sv
// Flags and outputs of the watchdog: status, arm, interrupt enable, cause,
// and the single reset pulse. Assumes hit is already qualified by rst_n.
module mwd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic por_n,
    input  logic hit,
    input  logic sts_clr,
    input  logic arm_set,
    input  logic ien_wr,
    input  logic ien_val,
    input  logic cause_clr,
    output logic sts,
    output logic arm,
    output logic ien,
    output logic cause,
    output logic irq,
    output logic rst_req
);
    logic fired;
    logic fire;

    assign fire = hit && arm;

    // Status flag: a new equality takes priority over a write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       sts <= 1'b0;
        else if (hit)     sts <= 1'b1;
        else if (sts_clr) sts <= 1'b0;
    end

    // Arm bit: set-only from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       arm <= 1'b0;
        else if (arm_set) arm <= 1'b1;
    end

    // Interrupt enable: plain read/write bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= 1'b0;
        else if (ien_wr) ien <= ien_val;
    end

    // Reset pulse, issued once until the next system reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            fired   <= 1'b0;
        end else begin
            rst_req <= fire && !fired;
            fired   <= fired || fire;
        end
    end

    // Cause flag: only power-on clears it by reset, so it outlives rst_n.
    always_ff @(posedge clk) begin
        if (!por_n)         cause <= 1'b0;
        else if (!rst_n)    cause <= cause;
        else if (fire)      cause <= 1'b1;
        else if (cause_clr) cause <= 1'b0;
    end

    assign irq = sts && ien;

    // R5: the request is never longer than one cycle
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R5: a request only comes out of an armed block
    a_r5_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> arm);
    // R4: once armed, stays armed until reset
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> arm);
    // R7: the cause flag is set alongside the request
    a_r7_cause_with_req: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rst_req |-> cause);
    // R3: a request always has the status flag beside it
    a_r3_sts_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> sts);
endmodule

// File: rtl/mwd_top.sv
// Match-compare watchdog top: bus decode, read mux, and the three submodules.
// Assumes single-cycle accesses with full-word writes.
module mwd_top
    import mwd_pkg::*;
#(
    parameter int unsigned       DW      = DATA_W,
    parameter int unsigned       AW      = ADDR_W,
    parameter logic [DW-1:0]     TGT_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          wdog_rst_req
);
    logic          wen;
    logic [DW-1:0] cnt;
    logic [DW-1:0] tgt;
    logic          hit;
    logic          sts;
    logic          arm;
    logic          ien;
    logic          cause;

    assign wen = bus_sel && bus_wr;

    mwd_count #(.W(DW)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (wen && bus_addr == AW'(OFS_CNT)),
        .ld_val (bus_wdata),
        .cnt    (cnt)
    );

    mwd_match #(.W(DW), .RST_VAL(TGT_RST)) u_match (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (wen && bus_addr == AW'(OFS_TGT)),
        .wval (bus_wdata),
        .cnt  (cnt),
        .tgt  (tgt),
        .hit  (hit)
    );

    mwd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_n    (por_n),
        .hit      (hit),
        .sts_clr  (wen && bus_addr == AW'(OFS_STS) && bus_wdata[0]),
        .arm_set  (wen && bus_addr == AW'(OFS_ARM) && bus_wdata[0]),
        .ien_wr   (wen && bus_addr == AW'(OFS_IEN)),
        .ien_val  (bus_wdata[0]),
        .cause_clr(wen && bus_addr == AW'(OFS_CAUSE) && bus_wdata[0]),
        .sts      (sts),
        .arm      (arm),
        .ien      (ien),
        .cause    (cause),
        .irq      (irq),
        .rst_req  (wdog_rst_req)
    );

    // Read mux: select the addressed register, zero for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_CNT))        bus_rdata = cnt;
        else if (bus_addr == AW'(OFS_TGT))   bus_rdata = tgt;
        else if (bus_addr == AW'(OFS_STS))   bus_rdata = DW'(sts);
        else if (bus_addr == AW'(OFS_ARM))   bus_rdata = DW'(arm);
        else if (bus_addr == AW'(OFS_IEN))   bus_rdata = DW'(ien);
        else if (bus_addr == AW'(OFS_CAUSE)) bus_rdata = DW'(cause);
    end

    // R6: the interrupt never rises without its enable
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);
endmodule

// File: tb/sim_mwd_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every clock, plus directed checks.
module sim_mwd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wdog_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mwd_top u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdog_rst_req(wdog_rst_req)
    );

    // Reference model state
    logic [31:0] m_cnt = 0, m_tgt = 32'hFFFF_FFFF;
    bit m_sts = 0, m_arm = 0, m_ien = 0, m_cause = 0, m_fired = 0, m_req = 0;

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_cnt;
            5'h04: return m_tgt;
            5'h08: return {31'd0, m_sts};
            5'h0C: return {31'd0, m_arm};
            5'h10: return {31'd0, m_ien};
            5'h14: return {31'd0, m_cause};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update at each edge from the inputs held since the last edge.
    always @(posedge clk) begin
        bit hit, w;
        hit = rst_n && (m_cnt == m_tgt);
        w   = bus_sel && bus_wr;
        if (!por_n) m_cause = 0;
        else if (rst_n && hit && m_arm) m_cause = 1;
        else if (rst_n && w && bus_addr == 5'h14 && bus_wdata[0]) m_cause = 0;
        if (!rst_n) begin
            m_cnt = 0; m_tgt = 32'hFFFF_FFFF; m_sts = 0; m_arm = 0;
            m_ien = 0; m_fired = 0; m_req = 0;
        end else begin
            m_req   = hit && m_arm && !m_fired;
            m_fired = m_fired || (hit && m_arm);
            if (hit) m_sts = 1;
            else if (w && bus_addr == 5'h08 && bus_wdata[0]) m_sts = 0;
            if (w && bus_addr == 5'h0C && bus_wdata[0]) m_arm = 1;
            if (w && bus_addr == 5'h10) m_ien = bus_wdata[0];
            if (w && bus_addr == 5'h04) m_tgt = bus_wdata;
            m_cnt = (w && bus_addr == 5'h00) ? bus_wdata : m_cnt + 1;
        end
    end

    // Compare against the model in the middle of every cycle.
    always @(negedge clk) begin
        if (rst_n && por_n) begin
            check("R5 model", {31'd0, wdog_rst_req}, {31'd0, m_req});
            check("R6 model", {31'd0, irq}, {31'd0, m_sts && m_ien});
            if (bus_sel && !bus_wr) check("R1 model read", bus_rdata, m_read(bus_addr));
        end
        if (wdog_rst_req) pulses++;
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        idle(4);
        rst_n = 1; por_n = 1;
        // R8 reset values
        rd(5'h04, v); check("R8 target reset", v, 32'hFFFF_FFFF);
        rd(5'h08, v); check("R8 status reset", v, 0);
        rd(5'h0C, v); check("R8 arm reset", v, 0);
        rd(5'h10, v); check("R8 ien reset", v, 0);
        rd(5'h14, v); check("R8 cause reset", v, 0);
        rd(5'h18, v); check("R8 unmapped", v, 0);
        // R1 counting and load
        rd(5'h00, v); rd(5'h00, v2);
        check("R1 step between reads", v2, v + 2);
        wr(5'h00, 32'h1234);
        rd(5'h00, v); check("R1 load then count", v, 32'h1235);
        // R2 same-cycle target write uses old target; R3 unarmed status
        wr(5'h10, 1);
        wr(5'h04, 101);
        wr(5'h00, 100);
        wr(5'h04, 500);
        rd(5'h08, v); check("R2 old target compared / R3 status set", v, 1);
        check("R6 irq with enable", {31'd0, irq}, 1);
        check("R5 no pulse unarmed", pulses, 0);
        // R3 write-1-to-clear
        wr(5'h08, 0); rd(5'h08, v); check("R3 write 0 keeps", v, 1);
        wr(5'h08, 1); rd(5'h08, v); check("R3 write 1 clears", v, 0);
        check("R6 irq low after clear", {31'd0, irq}, 0);
        // R2 wraparound match
        wr(5'h04, 32'h10);
        wr(5'h00, 32'hFFFF_FFF0);
        idle(40);
        rd(5'h08, v); check("R2 wrapped target matches", v, 1);
        wr(5'h08, 1);
        // R4 sticky arm
        wr(5'h0C, 1); wr(5'h0C, 0);
        rd(5'h0C, v); check("R4 write 0 ignored", v, 1);
        // R5 kicks hold off the request; R6 ien cleared
        wr(5'h10, 0);
        for (int i = 0; i < 5; i++) begin
            rd(5'h00, v); wr(5'h04, v + 60); idle(30);
        end
        check("R5 no pulse while kicked", pulses, 0);
        idle(80);
        check("R5 one pulse on lapse", pulses, 1);
        rd(5'h14, v); check("R7 cause set", v, 1);
        check("R6 irq masked", {31'd0, irq}, 0);
        rd(5'h00, v); wr(5'h04, v + 10); idle(20);
        check("R5 no second pulse", pulses, 1);
        // R7 cause survives system reset; R4 arm cleared by it
        @(posedge clk); #1; rst_n = 0; idle(3); rst_n = 1;
        rd(5'h0C, v); check("R4 arm cleared by rst_n", v, 0);
        rd(5'h14, v); check("R7 cause kept over rst_n", v, 1);
        wr(5'h14, 0); rd(5'h14, v); check("R7 write 0 keeps", v, 1);
        wr(5'h14, 1); rd(5'h14, v); check("R7 write 1 clears", v, 0);
        wr(5'h0C, 1); rd(5'h00, v); wr(5'h04, v + 10); idle(20);
        check("R5 pulse after re-arm", pulses, 2);
        rd(5'h14, v); check("R7 cause set again", v, 1);
        @(posedge clk); #1; rst_n = 0; por_n = 0; idle(2); rst_n = 1; por_n = 1;
        rd(5'h14, v); check("R7 power-on clears cause", v, 0);
        idle(4);
        finish_run();
    end
endmodule